// File: doc/BRIEF.md
# Cell Header Error-Control Receiver

This block sits at the receive side of a cell-based link, right after cell boundaries have been found. Each cell header reaches it as one parallel word: 32 header bits and an 8-bit check byte, marked by a one-cycle valid strobe. The block recomputes the CRC-8 over the header bits and XORs the result with the received check byte to form a syndrome. The syndrome sorts the header into one of three classes: clean, a single flipped bit that can be located, or an error that cannot be repaired.

A two-state mode register then makes the pass or drop decision. In the correcting state, a single-bit error is repaired and the header passes, but any error moves the receiver into a guarded state. In the guarded state, every header with an error is dropped. The first clean header returns the receiver to the correcting state. One clock after each valid input, the block drives the header (repaired where that applies) together with exactly one of a pass strobe or a discard strobe. It also shows the error class and the current mode.

Top module: `hec_rx`

## Requirements
- R1: The expected check byte is the remainder of the 32 header bits times x^8, divided by x^8 + x^2 + x + 1, XORed with the parameter `COSET` (default 0). The header is `in_hdr`, with bit 31 first. A header whose `in_chk` equals this value is clean.
- R2: While `rst` is high and on the cycle after it, `out_mode` is 0 (correcting) and neither strobe is asserted.
- R3: In correcting mode, a clean header is passed with `out_hdr` equal to `in_hdr`, and `out_mode` stays 0.
- R4: In correcting mode, a header with exactly one flipped header bit is passed with that bit restored, and `out_mode` becomes 1 (guarded).
- R5: In correcting mode, a header with exactly one flipped check-byte bit is passed with `out_hdr` equal to `in_hdr`, and `out_mode` becomes 1.
- R6: In correcting mode, a header whose syndrome matches none of the 40 single-bit syndromes is discarded, and `out_mode` becomes 1.
- R7: In guarded mode, any header with an error (single or multi) is discarded, and `out_mode` stays 1.
- R8: In guarded mode, a clean header is passed unchanged, and `out_mode` returns to 0.
- R9: For every cycle with `in_valid` high, exactly one of `out_pass` or `out_discard` is high on the following cycle. Neither strobe is high on a cycle that follows no valid input.
- R10: Cycles with `in_valid` low leave `out_mode` unchanged.
- R11: `out_class` is registered with the strobes and encodes 0 for clean, 1 for single-bit and 2 for multi-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header word present this cycle |
| in_hdr | input | 32 | Received header bits |
| in_chk | input | 8 | Received check byte |
| out_hdr | output | 32 | Header, repaired where that applies, one cycle after valid |
| out_pass | output | 1 | Header accepted |
| out_discard | output | 1 | Header dropped |
| out_class | output | 2 | Error class: 0 clean, 1 single, 2 multi |
| out_mode | output | 1 | 0 correcting, 1 guarded |

## Verification
The assertions assume that reset is held for at least two cycles before the first header, and that `in_valid` is never unknown after reset. Under that assumption, the strobe and mode properties follow from the valid timing alone. The multi-bit cases in the stimulus use two flipped bits. With this generator, two flips give a syndrome of even weight in the x+1 factor, so they can never alias to a single-bit syndrome and the expected class is always multi. The directed tasks drive headers one at a time, with idle gaps between them. Every mode transition is reached from a known mode, because each task first sends a clean header to return the receiver to correcting mode.

// File: rtl/hec_pkg.sv
package hec_pkg;

    localparam int HDR_W = 32;
    localparam int CHK_W = 8;
    localparam int CW_W  = HDR_W + CHK_W;
    localparam logic [CHK_W-1:0] GEN_LOW = 8'h07;  // x^2 + x + 1, x^8 implicit

    typedef enum logic [1:0] {
        HEC_NONE   = 2'd0,
        HEC_SINGLE = 2'd1,
        HEC_MULTI  = 2'd2
    } hec_class_e;

    typedef enum logic {
        MODE_CORRECT = 1'b0,
        MODE_DETECT  = 1'b1
    } hec_mode_e;

    typedef struct packed {
        hec_class_e       cls;
        logic [HDR_W-1:0] fix;   // bits of the header to invert
    } hec_verdict_t;

    // Remainder of data * x^8 modulo the generator, bit HDR_W-1 first.
    function automatic logic [CHK_W-1:0] crc_rem(input logic [HDR_W-1:0] data);
        logic [CHK_W-1:0] r;
        logic             fb;
        r = '0;
        for (int k = HDR_W - 1; k >= 0; k--) begin
            fb = r[CHK_W-1] ^ data[k];
            r  = {r[CHK_W-2:0], 1'b0};
            if (fb) r = r ^ GEN_LOW;
        end
        return r;
    endfunction

    // Syndrome produced by flipping codeword bit pos (0..7 check, 8..39 header).
    function automatic logic [CHK_W-1:0] unit_syndrome(input int pos);
        logic [CHK_W-1:0] s;
        logic [HDR_W-1:0] d;
        s = '0;
        d = '0;
        if (pos < CHK_W) begin
            s[pos] = 1'b1;
        end else begin
            d[pos - CHK_W] = 1'b1;
            s = crc_rem(d);
        end
        return s;
    endfunction

endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
    import hec_pkg::*;
#(
    parameter logic [CHK_W-1:0] COSET = '0
) (
    input  logic [HDR_W-1:0] hdr,
    input  logic [CHK_W-1:0] chk,
    output logic [CHK_W-1:0] syn
);
    logic [CHK_W-1:0] expect_chk;

    always_comb begin
        expect_chk = crc_rem(hdr) ^ COSET;
        syn        = expect_chk ^ chk;
    end
endmodule

// File: rtl/hec_locator.sv
module hec_locator
    import hec_pkg::*;
(
    input  logic [CHK_W-1:0] syn,
    output hec_verdict_t     verdict
);
    logic [CW_W-1:0] hit;

    for (genvar p = 0; p < CW_W; p++) begin : g_cmp
        localparam logic [CHK_W-1:0] SIG = unit_syndrome(p);
        assign hit[p] = (syn == SIG);
    end

    always_comb begin
        verdict.fix = hit[CW_W-1:CHK_W];
        if (syn == '0)
            verdict.cls = HEC_NONE;
        else if (|hit)
            verdict.cls = HEC_SINGLE;
        else
            verdict.cls = HEC_MULTI;
    end
endmodule

// File: rtl/hec_mode_fsm.sv
module hec_mode_fsm
    import hec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  hec_class_e cls,
    output logic       accept,     // combinational decision for this header
    output logic       pass_q,
    output logic       drop_q,
    output hec_mode_e  mode_q
);
    hec_mode_e mode_nx;

    always_comb begin
        accept  = (cls == HEC_NONE) ||
                  ((cls == HEC_SINGLE) && (mode_q == MODE_CORRECT));
        mode_nx = (cls == HEC_NONE) ? MODE_CORRECT : MODE_DETECT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_CORRECT;
            pass_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            pass_q <= valid && accept;
            drop_q <= valid && !accept;
            if (valid) mode_q <= mode_nx;
        end
    end
endmodule

// File: rtl/hec_rx.sv
module hec_rx
    import hec_pkg::*;
#(
    parameter logic [7:0] COSET = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_hdr,
    input  logic [7:0]  in_chk,
    output logic [31:0] out_hdr,
    output logic        out_pass,
    output logic        out_discard,
    output logic [1:0]  out_class,
    output logic        out_mode
);
    logic [CHK_W-1:0] syn;
    hec_verdict_t     verdict;
    logic             accept;
    hec_mode_e        mode_q;
    logic [HDR_W-1:0] hdr_q;
    hec_class_e       cls_q;

    hec_syndrome #(.COSET(COSET)) u_syn (
        .hdr (in_hdr),
        .chk (in_chk),
        .syn (syn)
    );

    hec_locator u_loc (
        .syn     (syn),
        .verdict (verdict)
    );

    hec_mode_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .cls    (verdict.cls),
        .accept (accept),
        .pass_q (out_pass),
        .drop_q (out_discard),
        .mode_q (mode_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
            cls_q <= HEC_NONE;
        end else if (in_valid) begin
            hdr_q <= (accept && verdict.cls == HEC_SINGLE) ? (in_hdr ^ verdict.fix) : in_hdr;
            cls_q <= verdict.cls;
        end
    end

    assign out_hdr   = hdr_q;
    assign out_class = cls_q;
    assign out_mode  = mode_q;
endmodule

// File: rtl/hec_rx_chk.sv
module hec_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       out_pass,
    input logic       out_discard,
    input logic [1:0] out_class,
    input logic       out_mode
);
    // R9
    one_strobe_per_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_pass ^ out_discard));

    // R9
    no_strobe_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_pass && !out_discard));

    // R10
    mode_held_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_mode));

    // R6
    discard_leaves_guarded_chk: assert property (@(posedge clk) disable iff (rst)
        out_discard |-> out_mode);

    // R8
    clean_returns_correcting_chk: assert property (@(posedge clk) disable iff (rst)
        (out_pass && out_class == 2'd0) |-> !out_mode);

    // R7
    guarded_single_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(out_mode) && (out_pass || out_discard) && out_class == 2'd1) |-> out_discard);

    // R11
    multi_always_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        ((out_pass || out_discard) && out_class == 2'd2) |-> out_discard);

    // R2
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_mode && !out_pass && !out_discard));
endmodule

bind hec_rx hec_rx_chk u_hec_rx_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .out_pass    (out_pass),
    .out_discard (out_discard),
    .out_class   (out_class),
    .out_mode    (out_mode)
);

// File: tb/test_hec_rx.sv
module test_hec_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_hdr = '0;
    logic [7:0]  in_chk = '0;
    logic [31:0] out_hdr;
    logic        out_pass;
    logic        out_discard;
    logic [1:0]  out_class;
    logic        out_mode;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    hec_rx i_hec_rx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr), .in_chk(in_chk),
        .out_hdr(out_hdr), .out_pass(out_pass), .out_discard(out_discard),
        .out_class(out_class), .out_mode(out_mode)
    );

    // Reference check byte by long division of the 40-bit dividend.
    function automatic logic [7:0] ref_chk(input logic [31:0] h);
        logic [39:0] dv;
        dv = {h, 8'h00};
        for (int k = 39; k >= 8; k--)
            if (dv[k]) dv[k -: 9] = dv[k -: 9] ^ 9'h107;
        return dv[7:0];
    endfunction

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one header, then sample one cycle later away from the edge.
    task automatic push(input string req, input logic [31:0] h, input logic [7:0] c,
                        input logic pass, input logic [31:0] hdr_exp,
                        input logic [1:0] cls, input logic mode);
        @(negedge clk);
        in_valid = 1'b1; in_hdr = h; in_chk = c;
        @(negedge clk);
        in_valid = 1'b0;
        expect_eq(req, "pass",    32'(out_pass),    32'(pass));
        expect_eq(req, "discard", 32'(out_discard), 32'(!pass));
        expect_eq(req, "class",   32'(out_class),   32'(cls));
        expect_eq(req, "mode",    32'(out_mode),    32'(mode));
        if (pass) expect_eq(req, "hdr", out_hdr, hdr_exp);
    endtask

    task automatic to_correcting(input logic [31:0] h);
        push("R8", h, ref_chk(h), 1'b1, h, 2'd0, 1'b0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        expect_eq("R2", "mode", 32'(out_mode), 32'd0);
        expect_eq("R2", "strobes", 32'({out_pass, out_discard}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R2", "mode after", 32'(out_mode), 32'd0);
    endtask

    task automatic t_clean;
        logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001};
        foreach (pats[k]) begin
            push("R1", pats[k], ref_chk(pats[k]), 1'b1, pats[k], 2'd0, 1'b0);
            push("R3", pats[k] ^ 32'h0F0F_0000, ref_chk(pats[k] ^ 32'h0F0F_0000),
                 1'b1, pats[k] ^ 32'h0F0F_0000, 2'd0, 1'b0);
        end
    endtask

    task automatic t_single_hdr;
        int pos [4] = '{0, 7, 19, 31};
        logic [31:0] h;
        foreach (pos[k]) begin
            h = 32'hA5C3_1E77 + 32'(k);
            to_correcting(h);
            push("R4", h ^ (32'd1 << pos[k]), ref_chk(h), 1'b1, h, 2'd1, 1'b1);
        end
    endtask

    task automatic t_single_chk;
        logic [31:0] h;
        h = 32'h0BAD_F00D;
        for (int b = 0; b < 8; b += 3) begin
            to_correcting(h);
            push("R5", h, ref_chk(h) ^ (8'd1 << b), 1'b1, h, 2'd1, 1'b1);
        end
    endtask

    task automatic t_multi;
        logic [31:0] h;
        h = 32'h3C3C_A5A5;
        to_correcting(h);
        push("R6", h ^ 32'h0000_0011, ref_chk(h), 1'b0, h, 2'd2, 1'b1);
        to_correcting(h);
        push("R11", h ^ 32'h8000_0000, ref_chk(h) ^ 8'h40, 1'b0, h, 2'd2, 1'b1);
    endtask

    task automatic t_guarded;
        logic [31:0] h;
        h = 32'h7654_3210;
        to_correcting(h);
        push("R6", h ^ 32'h0000_0300, ref_chk(h), 1'b0, h, 2'd2, 1'b1);
        push("R7", h ^ 32'h0001_0000, ref_chk(h), 1'b0, h, 2'd1, 1'b1);
        push("R7", h, ref_chk(h) ^ 8'h02, 1'b0, h, 2'd1, 1'b1);
        push("R7", h ^ 32'h0000_0005, ref_chk(h), 1'b0, h, 2'd2, 1'b1);
        push("R8", h, ref_chk(h), 1'b1, h, 2'd0, 1'b0);
    endtask

    task automatic t_idle;
        logic [31:0] h;
        h = 32'hDEAD_BEEF;
        to_correcting(h);
        push("R4", h ^ 32'h0000_1000, ref_chk(h), 1'b1, h, 2'd1, 1'b1);
        repeat (5) begin
            @(negedge clk);
            expect_eq("R10", "mode idle", 32'(out_mode), 32'd1);
            expect_eq("R9", "strobes idle", 32'({out_pass, out_discard}), 32'd0);
        end
        // back-to-back valids: one strobe each
        @(negedge clk);
        in_valid = 1'b1; in_hdr = h; in_chk = ref_chk(h);
        @(negedge clk);
        expect_eq("R9", "b2b first", 32'({out_pass, out_discard}), 32'b10);
        in_hdr = h ^ 32'h3; in_chk = ref_chk(h);
        @(negedge clk);
        in_valid = 1'b0;
        expect_eq("R9", "b2b second", 32'({out_pass, out_discard}), 32'b01);
        expect_eq("R11", "b2b class", 32'(out_class), 32'd2);
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_clean();
        t_single_hdr();
        t_single_chk();
        t_multi();
        t_guarded();
        t_idle();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule